// File: doc/BRIEF.md
# Single-Bus Microcoded CPU Datapath

This block is the data side of a microprogrammed 32-bit processor in which every transfer travels over one shared bus. An external microsequencer presents a flat control word each clock cycle. The word names at most one source for the bus: the immediate extender, the ALU, the register file or the incoming memory data. It also names any set of destinations that capture the bus value at the next rising edge: the instruction register, the ALU operand latches A and B, the memory address latch, and the register file. The register file holds the 32 general registers and keeps the program counter as entry 32 of the same array. A macro-instruction therefore runs as a short chain of bus transfers, such as copying the program counter into A, feeding A+4 back into the program counter, or forming a jump target from A and B.

Two signals go back to the sequencer: the opcode field of the instruction register, and a flag that is high when latch A holds zero. The memory side consists of the address latch output, a write data bus and a write strobe, and it has no handshake. The sequencer waits out slow memory itself, and the block keeps no flow-control state.

Top module: `sbus_datapath`

## Requirements
- R1: The bus carries the source whose drive enable is high: `ctl_drv_imm` gives the extender output, `ctl_drv_alu` the ALU result, `ctl_drv_reg` the selected register, and `ctl_drv_mem` the value on `mem_rdata`. With no enable high the bus reads as zero. More than one enable high at once is illegal.
- R2: On a rising edge, each of IR, A, B and the memory address latch captures the bus value of that cycle when its load signal is high. When its load signal is low, the latch keeps its value.
- R3: `ctl_reg_sel` picks the register index for both the read and the write: 0 picks IR bits [15:11], 1 picks IR bits [20:16], 2 picks IR bits [25:21], 3 picks index 32 (the program counter) and 4 picks index 31 (the link register). Codes 5 to 7 pick index 0. When `ctl_reg_wr` is high, the selected entry takes the bus value at the edge. Index 0 always reads as zero, and writes to it are discarded.
- R4: `opcode` shows IR bits [31:26]. The immediate is IR bits [15:0].
- R5: `ctl_ext_sel` 0 gives the sign-extended immediate, 1 the zero-extended immediate, and 2 the sign-extended immediate shifted left by two. Code 3 gives zero.
- R6: The ALU operation codes are 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 A+4, 6 jump target {A[31:28], B[25:0], 2'b00} and 7 pass B. With `ctl_op_from_ir` high, the code is taken from IR bits [2:0] and not from `ctl_alu_op`.
- R7: `a_is_zero` is high exactly when latch A holds zero.
- R8: `mem_addr` shows the address latch. `mem_wdata` shows the bus in the same cycle, and `mem_we` follows `ctl_mem_wr` in the same cycle.
- R9: A synchronous reset clears IR, A, B, the address latch, the program counter and all general registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctl_ld_ir | input | 1 | Load instruction register from the bus |
| ctl_ld_a | input | 1 | Load operand latch A from the bus |
| ctl_ld_b | input | 1 | Load operand latch B from the bus |
| ctl_ld_ma | input | 1 | Load memory address latch from the bus |
| ctl_drv_imm | input | 1 | Extender drives the bus |
| ctl_drv_alu | input | 1 | ALU drives the bus |
| ctl_drv_reg | input | 1 | Selected register drives the bus |
| ctl_drv_mem | input | 1 | Memory read data drives the bus |
| ctl_reg_wr | input | 1 | Write the bus into the selected register |
| ctl_mem_wr | input | 1 | Memory write strobe request |
| ctl_op_from_ir | input | 1 | Take the ALU code from IR bits [2:0] |
| ctl_reg_sel | input | 3 | Register index source |
| ctl_ext_sel | input | 2 | Extender mode |
| ctl_alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Data returned by memory |
| mem_addr | output | 32 | Memory address latch |
| mem_wdata | output | 32 | Memory write data (the bus) |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | IR opcode field for the sequencer |
| a_is_zero | output | 1 | Latch A equals zero |

## Verification
The assertions check on every cycle that no two bus sources are enabled at once, that A and the zero flag follow the value captured from the bus, that the address latch holds while it is not loaded, that a jump target keeps A's top nibble and a clear low pair of bits, and that a write to the program counter takes effect. The bench scenarios are the only place where the field decode of the register select, the discarding of writes to register 0, each extender mode, each ALU code including the code taken from IR, the zero bus with no driver, and the reset values are shown, all observed through the bus at `mem_wdata`.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int XLEN = 32;
  localparam int NGPR = 32;

  typedef enum logic [2:0] {
    SEL_RD   = 3'd0,
    SEL_RT   = 3'd1,
    SEL_RS   = 3'd2,
    SEL_PC   = 3'd3,
    SEL_LINK = 3'd4
  } rsel_e;

  typedef enum logic [1:0] {
    EXT_SIGN   = 2'd0,
    EXT_ZERO   = 2'd1,
    EXT_SIGN_2 = 2'd2
  } ext_e;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_AND   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_XOR   = 3'd4,
    ALU_INC4  = 3'd5,
    ALU_JTARG = 3'd6,
    ALU_PASSB = 3'd7
  } alu_e;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int NREG   = 33,
  parameter int W      = 32,
  parameter int PC_IDX = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [NREG];
  logic         valid_idx;

  assign valid_idx = (idx != '0) && (32'(idx) < NREG);
  assign rdata     = valid_idx ? store[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
    end else if (we && valid_idx) begin
      store[idx] <= wdata;
    end
  end

  a_r3_pc_write: assert property (@(posedge clk) disable iff (rst)
    (we && 32'(idx) == PC_IDX) |=> (store[PC_IDX] == $past(wdata)));
endmodule

// File: rtl/sbus_immext.sv
module sbus_immext
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [15:0]  imm,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      EXT_SIGN:   y = {{(W-16){imm[15]}}, imm};
      EXT_ZERO:   y = {{(W-16){1'b0}}, imm};
      EXT_SIGN_2: y = {{(W-18){imm[15]}}, imm, 2'b00};
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (alu_e'(op))
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_INC4:  y = a + W'(4);
      ALU_JTARG: y = {a[W-1:W-4], b[W-7:0], 2'b00};
      default:   y = b;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int NGP   = NGPR,
  localparam int NREG = NGP + 1,
  localparam int AW   = $clog2(NREG),
  localparam int PCI  = NGP,
  localparam int LNKI = NGP - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctl_ld_ir,
  input  logic         ctl_ld_a,
  input  logic         ctl_ld_b,
  input  logic         ctl_ld_ma,
  input  logic         ctl_drv_imm,
  input  logic         ctl_drv_alu,
  input  logic         ctl_drv_reg,
  input  logic         ctl_drv_mem,
  input  logic         ctl_reg_wr,
  input  logic         ctl_mem_wr,
  input  logic         ctl_op_from_ir,
  input  logic [2:0]   ctl_reg_sel,
  input  logic [1:0]   ctl_ext_sel,
  input  logic [2:0]   ctl_alu_op,
  input  logic [31:0]  mem_rdata,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  output logic         mem_we,
  output logic [5:0]   opcode,
  output logic         a_is_zero
);
  logic [W-1:0]  ir_q, a_q, b_q, ma_q;
  logic [W-1:0]  bus, imm_v, alu_v, reg_v;
  logic [AW-1:0] ridx;
  logic [2:0]    op_eff;

  always_comb begin
    unique case (rsel_e'(ctl_reg_sel))
      SEL_RD:   ridx = AW'(ir_q[15:11]);
      SEL_RT:   ridx = AW'(ir_q[20:16]);
      SEL_RS:   ridx = AW'(ir_q[25:21]);
      SEL_PC:   ridx = AW'(PCI);
      SEL_LINK: ridx = AW'(LNKI);
      default:  ridx = '0;
    endcase
  end

  assign op_eff = ctl_op_from_ir ? ir_q[2:0] : ctl_alu_op;

  sbus_regfile #(.NREG(NREG), .W(W), .PC_IDX(PCI)) u_rf (
    .clk(clk), .rst(rst), .idx(ridx), .we(ctl_reg_wr),
    .wdata(bus), .rdata(reg_v)
  );

  sbus_immext #(.W(W)) u_ext (.imm(ir_q[15:0]), .sel(ctl_ext_sel), .y(imm_v));

  sbus_alu #(.W(W)) u_alu (.a(a_q), .b(b_q), .op(op_eff), .y(alu_v));

  assign bus = ({W{ctl_drv_imm}} & imm_v)
             | ({W{ctl_drv_alu}} & alu_v)
             | ({W{ctl_drv_reg}} & reg_v)
             | ({W{ctl_drv_mem}} & mem_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ctl_ld_ir) ir_q <= bus;
      if (ctl_ld_a)  a_q  <= bus;
      if (ctl_ld_b)  b_q  <= bus;
      if (ctl_ld_ma) ma_q <= bus;
    end
  end

  assign opcode    = ir_q[31:26];
  assign a_is_zero = (a_q == '0);
  assign mem_addr  = ma_q;
  assign mem_wdata = bus;
  assign mem_we    = ctl_mem_wr;

  a_r1_one_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_drv_imm, ctl_drv_alu, ctl_drv_reg, ctl_drv_mem}));

  a_r2_a_capture: assert property (@(posedge clk) disable iff (rst)
    ctl_ld_a |=> (a_q == $past(bus)));

  a_r2_ma_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_ld_ma |=> $stable(mem_addr));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    ctl_ld_a |=> (a_is_zero == ($past(bus) == '0)));

  a_r6_jtarg: assert property (@(posedge clk) disable iff (rst)
    (ctl_drv_alu && op_eff == ALU_JTARG) |->
      (mem_wdata[1:0] == 2'b00 && mem_wdata[31:28] == a_q[31:28]));
endmodule

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_ir, ld_a, ld_b, ld_ma, d_imm, d_alu, d_reg, d_mem, reg_wr, mem_wr, fir;
  logic [2:0] rsel, aop;
  logic [1:0] esel;
  logic [31:0] rdata;
  logic [31:0] maddr, wdata;
  logic we, azero;
  logic [5:0] opc;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbus_datapath u0 (
    .clk(clk), .rst(rst), .ctl_ld_ir(ld_ir), .ctl_ld_a(ld_a), .ctl_ld_b(ld_b),
    .ctl_ld_ma(ld_ma), .ctl_drv_imm(d_imm), .ctl_drv_alu(d_alu), .ctl_drv_reg(d_reg),
    .ctl_drv_mem(d_mem), .ctl_reg_wr(reg_wr), .ctl_mem_wr(mem_wr),
    .ctl_op_from_ir(fir), .ctl_reg_sel(rsel), .ctl_ext_sel(esel), .ctl_alu_op(aop),
    .mem_rdata(rdata), .mem_addr(maddr), .mem_wdata(wdata), .mem_we(we),
    .opcode(opc), .a_is_zero(azero)
  );

  // instruction words: opcode 23h, rs=3, rt=5, rd=7, imm=3801h (func low bits 1)
  localparam logic [31:0] W1 = {6'h23, 5'd3, 5'd5, 16'h3801};
  // opcode 0Fh, rs=0, rt=0, rd=31, imm=FFF8h
  localparam logic [31:0] W2 = {6'h0F, 5'd0, 5'd0, 16'hFFF8};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    {ld_ir, ld_a, ld_b, ld_ma, d_imm, d_alu, d_reg, d_mem, reg_wr, mem_wr, fir} = '0;
    rsel = 3'd0; esel = 2'd0; aop = 3'd0; rdata = '0;
  endtask

  // drv bits: 3 mem,2 reg,1 alu,0 imm ; ld bits: 3 ma,2 b,1 a,0 ir
  task automatic cyc(input logic [3:0] drv, input logic [3:0] ld, input logic [2:0] sel,
                     input logic [1:0] ext, input logic [2:0] op, input logic f,
                     input logic rw, input logic [31:0] md);
    @(negedge clk);
    {d_mem, d_reg, d_alu, d_imm} = drv;
    {ld_ma, ld_b, ld_a, ld_ir} = ld;
    rsel = sel; esel = ext; aop = op; fir = f; reg_wr = rw; rdata = md;
    @(posedge clk);
    #1 clr();
  endtask

  task automatic look(input string req, input logic [3:0] drv, input logic [2:0] sel,
                      input logic [1:0] ext, input logic [2:0] op, input logic f,
                      input logic [31:0] exp);
    @(negedge clk);
    {d_mem, d_reg, d_alu, d_imm} = drv;
    rsel = sel; esel = ext; aop = op; fir = f;
    #1 chk(req, wdata, exp);
    @(posedge clk);
    #1 clr();
  endtask

  task automatic load_ir(input logic [31:0] w);
    cyc(4'b1000, 4'b0001, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, w);
  endtask

  task automatic t_reset();
    #2;
    chk("R9 opcode", {26'd0, opc}, 32'd0);
    chk("R9 a_is_zero", {31'd0, azero}, 32'd1);
    chk("R9 mem_addr", maddr, 32'd0);
    look("R9 pc", 4'b0100, 3'd3, 2'd0, 3'd0, 1'b0, 32'd0);
    look("R9 link", 4'b0100, 3'd4, 2'd0, 3'd0, 1'b0, 32'd0);
  endtask

  task automatic t_ir_ext();
    load_ir(W1);
    chk("R4 opcode", {26'd0, opc}, 32'h23);
    look("R5 zext", 4'b0001, 3'd0, 2'd1, 3'd0, 1'b0, 32'h0000_3801);
    load_ir(W2);
    chk("R4 opcode2", {26'd0, opc}, 32'h0F);
    look("R5 sext", 4'b0001, 3'd0, 2'd0, 3'd0, 1'b0, 32'hFFFF_FFF8);
    look("R5 zext neg", 4'b0001, 3'd0, 2'd1, 3'd0, 1'b0, 32'h0000_FFF8);
    look("R5 sext shift2", 4'b0001, 3'd0, 2'd2, 3'd0, 1'b0, 32'hFFFF_FFE0);
    look("R5 code3 zero", 4'b0001, 3'd0, 2'd3, 3'd0, 1'b0, 32'h0);
  endtask

  task automatic t_regs();
    load_ir(W1);
    // write 3801h into rt (5), 77h via memory into rd (7)
    cyc(4'b0001, 4'b0000, 3'd1, 2'd0, 3'd0, 1'b0, 1'b1, '0);
    cyc(4'b1000, 4'b0000, 3'd0, 2'd0, 3'd0, 1'b0, 1'b1, 32'h77);
    look("R3 rt read", 4'b0100, 3'd1, 2'd0, 3'd0, 1'b0, 32'h3801);
    look("R3 rd read", 4'b0100, 3'd0, 2'd0, 3'd0, 1'b0, 32'h77);
    look("R3 rs untouched", 4'b0100, 3'd2, 2'd0, 3'd0, 1'b0, 32'h0);
    // link register (31) write, seen as rd under W2 (rd=31)
    cyc(4'b1000, 4'b0000, 3'd4, 2'd0, 3'd0, 1'b0, 1'b1, 32'hCAFE_0001);
    load_ir(W2);
    look("R3 link is 31", 4'b0100, 3'd0, 2'd0, 3'd0, 1'b0, 32'hCAFE_0001);
    // x0: rt=0 under W2, write discarded
    cyc(4'b1000, 4'b0000, 3'd1, 2'd0, 3'd0, 1'b0, 1'b1, 32'h1234_5678);
    look("R3 x0 zero", 4'b0100, 3'd1, 2'd0, 3'd0, 1'b0, 32'h0);
    look("R3 code5 zero", 4'b0100, 3'd5, 2'd0, 3'd0, 1'b0, 32'h0);
  endtask

  task automatic t_pc();
    cyc(4'b1000, 4'b0000, 3'd3, 2'd0, 3'd0, 1'b0, 1'b1, 32'h0000_1000);
    look("R3 pc write", 4'b0100, 3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_1000);
    cyc(4'b0100, 4'b0010, 3'd3, 2'd0, 3'd0, 1'b0, 1'b0, '0);      // A <- PC
    cyc(4'b0010, 4'b0000, 3'd3, 2'd0, 3'd5, 1'b0, 1'b1, '0);      // PC <- A+4
    look("R6 pc+4", 4'b0100, 3'd3, 2'd0, 3'd0, 1'b0, 32'h0000_1004);
  endtask

  task automatic t_alu();
    logic [31:0] a = 32'hA000_00F0, b = 32'h0345_6F0F;
    cyc(4'b1000, 4'b0010, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, a);
    cyc(4'b1000, 4'b0100, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, b);
    look("R6 add",  4'b0010, 3'd0, 2'd0, 3'd0, 1'b0, a + b);
    look("R6 sub",  4'b0010, 3'd0, 2'd0, 3'd1, 1'b0, a - b);
    look("R6 and",  4'b0010, 3'd0, 2'd0, 3'd2, 1'b0, a & b);
    look("R6 or",   4'b0010, 3'd0, 2'd0, 3'd3, 1'b0, a | b);
    look("R6 xor",  4'b0010, 3'd0, 2'd0, 3'd4, 1'b0, a ^ b);
    look("R6 inc4", 4'b0010, 3'd0, 2'd0, 3'd5, 1'b0, a + 32'd4);
    look("R6 jtarg", 4'b0010, 3'd0, 2'd0, 3'd6, 1'b0, {a[31:28], b[25:0], 2'b00});
    look("R6 passb", 4'b0010, 3'd0, 2'd0, 3'd7, 1'b0, b);
    load_ir(W1);  // IR[2:0] = 1 -> subtract, control code says add
    look("R6 op from ir", 4'b0010, 3'd0, 2'd0, 3'd0, 1'b1, a - b);
  endtask

  task automatic t_zero_bus();
    cyc(4'b1000, 4'b0010, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h8);
    chk("R7 nonzero A", {31'd0, azero}, 32'd0);
    cyc(4'b0000, 4'b0000, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, '0);
    chk("R2 A holds", {31'd0, azero}, 32'd0);
    look("R1 idle bus zero", 4'b0000, 3'd0, 2'd0, 3'd0, 1'b0, 32'h0);
    cyc(4'b0000, 4'b0010, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R1 undriven load gives zero", {31'd0, azero}, 32'd1);
  endtask

  task automatic t_mem();
    cyc(4'b1000, 4'b1000, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_2040);
    chk("R8 mem_addr", maddr, 32'h0000_2040);
    cyc(4'b1000, 4'b0000, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 32'h9);
    chk("R2 ma holds", maddr, 32'h0000_2040);
    @(negedge clk);
    d_reg = 1'b1; rsel = 3'd3; mem_wr = 1'b1;
    #1;
    chk("R8 mem_we", {31'd0, we}, 32'd1);
    chk("R8 wdata is bus", wdata, 32'h0000_1004);
    @(posedge clk);
    #1 clr();
    chk("R8 mem_we low", {31'd0, we}, 32'd0);
  endtask

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_ir_ext();
    t_regs();
    t_pc();
    t_alu();
    t_zero_bus();
    t_mem();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule